// File: doc/BRIEF.md
# Sequential Matrix Multiply Engine

This block multiplies two square matrices of signed operands, C = A x B, using a single multiply-accumulate datapath. One element of the result is computed at a time. Two internal operand buffers are filled through a simple write port. After a one-cycle start pulse the engine walks every output element in turn. It spends one clock on each product term of the inner sum and then two clocks storing the finished sum into an internal result buffer.

When the last element has been stored, a completion flag rises and stays high until the next accepted start. The result buffer can then be read through a registered read port. The schedule is fixed, so the run time depends only on the dimension: N*N*(N+2) clocks, which is 34816 clocks for the default 32x32 case with 8-bit operands and a 24-bit accumulator.

Top module: `seqmatmul`

## Requirements
- R1: After reset, `dataready` is low and `rd_data` is zero.
- R2: While `wr_en` is high, `wr_data` is stored in operand A at (`wr_row`,`wr_col`) when `wr_sel` is 0, and in operand B at that position when `wr_sel` is 1. One entry is stored per clock.
- R3: Each result entry C[i][j] equals the sum over k of A[i][k]*B[k][j]. Operands are two's complement DW-bit values, and the sum is a two's complement AW-bit value. This holds across the full operand range, including -128 times -128 on every term.
- R4: The accumulator starts from zero for every element, so nothing left over from an earlier element or an earlier run appears in a result.
- R5: `dataready` is first seen high exactly N*N*(N+2) clock edges after the edge that samples an accepted `start`. For the default N=32 this is 34816 edges.
- R6: Results are stored in row-major order, with the column index advancing before the row index. Element (0,N-1) is therefore already stored N*(N+2) edges after the start edge.
- R7: An accepted `start` clears `dataready` at the same edge. Without a new start, `dataready` then stays high once it is set.
- R8: A `start` pulse that arrives while a computation is running is ignored. It neither restarts the run nor changes its latency.
- R9: `rd_data` shows C[`rd_row`][`rd_col`] one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 1 | Operand select: 0 selects A, 1 selects B |
| wr_row | input | $clog2(N) | Operand write row |
| wr_col | input | $clog2(N) | Operand write column |
| wr_data | input | DW | Signed operand value |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| rd_row | input | $clog2(N) | Result read row |
| rd_col | input | $clog2(N) | Result read column |
| rd_data | output | AW | Registered result entry |
| dataready | output | 1 | High once every result entry is stored |

## Verification
The main function is tried with three operand patterns, and every result entry is compared against a model.

Random signed operands catch arithmetic and indexing faults. A run in which every operand is -128 follows a random run, which exposes sign extension errors, accumulator overflow and any residue carried between elements or runs. A random A times an identity B must reproduce A exactly, which separates a correct store layout from swapped rows and columns.

During the second run, a probe of element (0,N-1) partway through distinguishes row-major from column-major order. A stray mid-run start pulse must leave the measured latency unchanged.

// File: rtl/smm_pkg.sv
package smm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MAC   = 2'd1,
      ST_SAVE  = 2'd2,
      ST_WRITE = 2'd3
   } smm_state_e;
endpackage

// File: rtl/smm_store.sv
module smm_store #(
   parameter int W      = 8,
   parameter int DEPTH  = 1024,
   parameter bit REG_RD = 1'b0,
   localparam int ADW   = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [ADW-1:0] waddr,
   input  logic [W-1:0]   wdata,
   input  logic [ADW-1:0] raddr,
   output logic [W-1:0]   rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (REG_RD) begin : g_reg_rd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= mem[raddr];
         end
      end else begin : g_comb_rd
         assign rdata = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/smm_mac.sv
module smm_mac #(
   parameter int DW = 8,
   parameter int AW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          en,
   input  logic          first,
   input  logic          save,
   output logic [AW-1:0] result
);
   localparam int PW = 2 * DW;

   logic signed [PW-1:0] prod;
   logic        [AW-1:0] prod_ext;
   logic        [AW-1:0] acc;

   generate
      if (AW <= PW) begin : g_bad_aw
         $error("smm_mac: AW must exceed 2*DW");
      end
   endgenerate

   assign prod     = $signed(a) * $signed(b);
   assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         result <= '0;
      end else begin
         if (en)   acc    <= (first ? '0 : acc) + prod_ext;
         if (save) result <= acc;
      end
   end
endmodule

// File: rtl/smm_sequencer.sv
module smm_sequencer
   import smm_pkg::*;
#(
   parameter int N  = 32,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic [IW-1:0] row,
   output logic [IW-1:0] col,
   output logic [IW-1:0] kk,
   output logic          mac_en,
   output logic          mac_first,
   output logic          save,
   output logic          cwr,
   output logic          busy,
   output logic          done
);
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   smm_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         row   <= '0;
         col   <= '0;
         kk    <= '0;
         done  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_MAC;
                  row   <= '0;
                  col   <= '0;
                  kk    <= '0;
                  done  <= 1'b0;
               end
            end
            ST_MAC: begin
               if (kk == LAST) begin
                  kk    <= '0;
                  state <= ST_SAVE;
               end else begin
                  kk <= kk + IW'(1);
               end
            end
            ST_SAVE: state <= ST_WRITE;
            ST_WRITE: begin
               state <= ST_MAC;
               if (col == LAST) begin
                  col <= '0;
                  if (row == LAST) begin
                     row   <= '0;
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     row <= row + IW'(1);
                  end
               end else begin
                  col <= col + IW'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mac_en    = (state == ST_MAC);
   assign mac_first = mac_en && (kk == '0);
   assign save      = (state == ST_SAVE);
   assign cwr       = (state == ST_WRITE);
   assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/seqmatmul.sv
module seqmatmul #(
   parameter int N  = 32,
   parameter int DW = 8,
   parameter int AW = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic [$clog2(N)-1:0] wr_row,
   input  logic [$clog2(N)-1:0] wr_col,
   input  logic [DW-1:0]        wr_data,
   input  logic                 start,
   input  logic [$clog2(N)-1:0] rd_row,
   input  logic [$clog2(N)-1:0] rd_col,
   output logic [AW-1:0]        rd_data,
   output logic                 dataready
);
   localparam int IW    = $clog2(N);
   localparam int DEPTH = N * N;
   localparam int ADW   = $clog2(DEPTH);

   generate
      if (N < 2) begin : g_bad_n
         $error("seqmatmul: N must be at least 2");
      end
      if (AW < 2 * DW + IW) begin : g_bad_acc
         $error("seqmatmul: AW too small for N products");
      end
   endgenerate

   function automatic logic [ADW-1:0] lin(input logic [IW-1:0] r, input logic [IW-1:0] c);
      return ADW'(r) * ADW'(N) + ADW'(c);
   endfunction

   logic [IW-1:0]  row_ix, col_ix, k_ix;
   logic           mac_en, mac_first, save_en, c_we, seq_busy;
   logic [DW-1:0]  a_val, b_val;
   logic [AW-1:0]  sum_q;
   logic [ADW-1:0] c_waddr;

   assign c_waddr = lin(row_ix, col_ix);

   smm_sequencer #(.N(N)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .row(row_ix), .col(col_ix), .kk(k_ix),
      .mac_en(mac_en), .mac_first(mac_first), .save(save_en),
      .cwr(c_we), .busy(seq_busy), .done(dataready)
   );

   smm_store #(.W(DW), .DEPTH(DEPTH), .REG_RD(1'b0)) u_abuf (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && !wr_sel), .waddr(lin(wr_row, wr_col)), .wdata(wr_data),
      .raddr(lin(row_ix, k_ix)), .rdata(a_val)
   );

   smm_store #(.W(DW), .DEPTH(DEPTH), .REG_RD(1'b0)) u_bbuf (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && wr_sel), .waddr(lin(wr_row, wr_col)), .wdata(wr_data),
      .raddr(lin(k_ix, col_ix)), .rdata(b_val)
   );

   smm_mac #(.DW(DW), .AW(AW)) u_mac (
      .clk(clk), .rst_n(rst_n), .a(a_val), .b(b_val),
      .en(mac_en), .first(mac_first), .save(save_en), .result(sum_q)
   );

   smm_store #(.W(AW), .DEPTH(DEPTH), .REG_RD(1'b1)) u_cbuf (
      .clk(clk), .rst_n(rst_n),
      .we(c_we), .waddr(c_waddr), .wdata(sum_q),
      .raddr(lin(rd_row, rd_col)), .rdata(rd_data)
   );
endmodule

// File: rtl/smm_chk.sv
module smm_chk #(
   parameter int N   = 32,
   parameter int ADW = 10
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           dataready,
   input logic           busy,
   input logic           c_we,
   input logic [ADW-1:0] c_waddr
);
   localparam int TOTAL = N * N * (N + 2);

   int unsigned    elapsed;
   logic [ADW-1:0] exp_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed  <= 0;
         exp_addr <= '0;
      end else begin
         if (start && !busy) begin
            elapsed  <= 0;
            exp_addr <= '0;
         end else begin
            if (busy) elapsed <= elapsed + 1;
            if (c_we) exp_addr <= exp_addr + ADW'(1);
         end
      end
   end

   // R5 and R8: a restart on a stray start would break the count
   a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dataready) |-> elapsed == TOTAL);

   a_r5_done_after_store: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dataready) |-> $past(c_we));

   a_r6_row_major: assert property (@(posedge clk) disable iff (!rst_n)
      c_we |-> c_waddr == exp_addr);

   a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (!dataready && busy));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dataready && !start) |=> dataready);

   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || dataready));
endmodule

bind seqmatmul smm_chk #(.N(N), .ADW(ADW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .dataready(dataready),
   .busy(seq_busy), .c_we(c_we), .c_waddr(c_waddr)
);

// File: tb/seqmatmul_tb.sv
module seqmatmul_tb;
   localparam int N   = 32;
   localparam int DW  = 8;
   localparam int AW  = 24;
   localparam int IW  = $clog2(N);
   localparam int LAT = N * N * (N + 2);
   localparam int NPAT = 3;
   // kind 0: random A,B; 1: all -128; 2: random A, identity B
   localparam int PAT_KIND [NPAT] = '{0, 1, 2};
   localparam int PAT_SEED [NPAT] = '{17, 3, 91};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, wr_sel = 1'b0, start = 1'b0;
   logic [IW-1:0] wr_row = '0, wr_col = '0, rd_row = '0, rd_col = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_data;
   logic          dataready;

   int checks = 0, fails = 0;
   bit finished = 1'b0;
   int unsigned rs;
   int am [N][N];
   int bm [N][N];
   logic [AW-1:0] ec [N][N];

   always #4 clk = ~clk;

   seqmatmul #(.N(N), .DW(DW), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data), .start(start),
      .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data), .dataready(dataready)
   );

   function automatic int rnd8();
      rs = rs * 32'd1664525 + 32'd1013904223;
      return int'($signed(rs[23:16]));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   task automatic build(input int kind, input int seed);
      rs = seed;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            case (kind)
               0: begin am[i][j] = rnd8(); bm[i][j] = rnd8(); end
               1: begin am[i][j] = -128;   bm[i][j] = -128;   end
               default: begin am[i][j] = rnd8(); bm[i][j] = (i == j) ? 1 : 0; end
            endcase
         end
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            int s = 0;
            for (int k = 0; k < N; k++) s += am[i][k] * bm[k][j];
            ec[i][j] = AW'(s);
         end
   endtask

   task automatic load();
      for (int m = 0; m < 2; m++)
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
               @(negedge clk);
               wr_en = 1'b1; wr_sel = m[0];
               wr_row = IW'(i); wr_col = IW'(j);
               wr_data = DW'(m == 0 ? am[i][j] : bm[i][j]);
            end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(input int pi);
      int cnt = 0;
      rd_row = '0; rd_col = IW'(N - 1);
      if (pi > 0) chk("R7 held before start", 32'(dataready), 32'd1);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R7 cleared by start", 32'(dataready), 32'd0);
      while (1) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         start = 1'b0;
         if (pi == 1 && cnt == N * (N + 2) + 1)
            chk("R6 element (0,N-1) stored early", 32'(rd_data), 32'(ec[0][N-1]));
         if (pi == 1 && cnt == 2000) start = 1'b1;  // R8 stray start
         if (dataready) break;
         if (cnt > LAT + 100) break;
      end
      chk(pi == 1 ? "R5 R8 latency with stray start" : "R5 latency", cnt, LAT);
   endtask

   task automatic readback(input string tag);
      @(negedge clk);
      rd_row = '0; rd_col = '0;
      for (int e = 0; e < N * N; e++) begin
         @(negedge clk);
         chk(tag, 32'(rd_data), 32'(ec[e / N][e % N]));
         if (e + 1 < N * N) begin
            rd_row = IW'((e + 1) / N);
            rd_col = IW'((e + 1) % N);
         end
      end
      repeat (3) @(negedge clk);
      chk("R7 stays high after readback", 32'(dataready), 32'd1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 dataready at reset", 32'(dataready), 32'd0);
      chk("R1 rd_data at reset", 32'(rd_data), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int p = 0; p < NPAT; p++) begin
         build(PAT_KIND[p], PAT_SEED[p]);
         load();
         run(p);
         // R9 reads with one-clock latency; R3 random, R4 after prior run, R2 identity layout
         readback(p == 0 ? "R3 R9 random" : (p == 1 ? "R4 R3 extremes" : "R2 identity B"));
      end
      summary();
   end
endmodule